// File: doc/BRIEF.md
# Scrambled AMI Line Codec

This block is the digital datapath of one burst-mode twisted-pair subscriber line. On the transmit side it runs a serial bit stream through a self-synchronising scrambler built on x^9 + x^5 + 1. It then codes each scrambled bit as a ternary alternate-mark-inversion symbol, carried as a two-bit code. On the receive side it takes the ternary symbols the detector delivers and turns them back into line bits. It flags bipolar violations and runs the bits through the matching descrambler.

The loop carries 144 kb/s of 2B+D payload in full duplex. It does this by compressing time, so transmit and receive bursts alternate on the same pair. Each direction therefore has its own burst-window strobe, `tx_en_i` and `rx_en_i`. An external timing generator derived from the 4.096 MHz reference produces these strobes, one pulse per symbol. Between bursts both directions keep their scrambler history and mark polarity. Pulse shaping, equalisation, clock recovery and the analog front end sit outside this block.

Top module: `ami_line_codec`

## Requirements
- R1: The transmit symbol uses the codes 2'b00 for no pulse, 2'b01 for a positive mark and 2'b11 for a negative mark. The code 2'b10 never appears on `tx_sym_o`.
- R2: Every scrambled one is sent as a mark whose polarity is opposite to the previous mark. Every scrambled zero is sent as no pulse. The first mark after reset is positive.
- R3: The scrambled bit is s[n] = d[n] XOR s[n-5] XOR s[n-9], where s is the history of transmitted scrambled bits. That history is all zeros after reset.
- R4: `tx_sym_o` is registered. It shows the symbol for the bit sampled on the previous clock edge with `tx_en_i` high. After an edge with `tx_en_i` low it shows 2'b00.
- R5: While `tx_en_i` is low, the scrambler history and the mark polarity do not change. A later burst continues the sequence where the last burst stopped.
- R6: On receive, codes 2'b01 and 2'b11 are marks and decode to line bit one. Codes 2'b00 and 2'b10 decode to line bit zero and do not change the mark polarity reference.
- R7: The receive output is y[n] = l[n] XOR l[n-5] XOR l[n-9], where l is the history of received line bits (all zeros after reset). It appears on `rx_bit_o` one cycle after the edge where `rx_en_i` was high. `rx_valid_o` is high in exactly that cycle.
- R8: `rx_bpv_o` is high for one cycle, alongside `rx_valid_o`, when a received mark has the same polarity as the previous received mark. The reference polarity after reset is negative, so a first positive mark is legal and a first negative mark is a violation. Every mark, violating or not, becomes the new reference.
- R9: While `rx_en_i` is low, `rx_valid_o` and `rx_bpv_o` are low and `rx_bit_o` holds its last value. The descrambler history and the polarity reference do not change.
- R10: With `tx_sym_o` looped back into `rx_sym_i`, `rx_bit_o` reproduces the transmitted data. After a corrupted line symbol, output is correct again from the tenth line bit onward.
- R11: During reset `tx_sym_o` is 2'b00 and `rx_bit_o`, `rx_valid_o` and `rx_bpv_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Datapath clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit symbol strobe inside the transmit burst window |
| tx_bit_i | input | 1 | Transmit data bit, sampled when `tx_en_i` is high |
| tx_sym_o | output | 2 | Ternary transmit symbol code |
| rx_en_i | input | 1 | Receive symbol strobe inside the receive burst window |
| rx_sym_i | input | 2 | Detected ternary receive symbol code |
| rx_bit_o | output | 1 | Descrambled receive data bit |
| rx_valid_o | output | 1 | `rx_bit_o` was updated on the last edge |
| rx_bpv_o | output | 1 | Bipolar violation on the last received symbol |

## Verification
The assertions check the following on every cycle: the transmit code stays legal, consecutive transmit marks alternate starting from positive, and the transmit output returns to zero outside a burst. They also check that both shift histories freeze while their strobe is low, that a violation flag never appears without a valid bit, and that the receive bit holds between bursts. The actual scrambler and descrambler arithmetic, and the choice of which received marks count as violations, can only be shown by the bench. It compares every output against its own model across random bursts, illegal receive codes and forced same-polarity marks. Recovery after line errors is likewise a bench-only matter: the bench loops transmit back into receive, injects errors, and checks that data is recovered once ten clean line bits have passed.

// File: rtl/ami_codec_pkg.sv
package ami_codec_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_POS  = 2'b01,
    SYM_BAD  = 2'b10,
    SYM_NEG  = 2'b11
  } sym_e;

  localparam int unsigned TAP_NEAR = 5;
  localparam int unsigned TAP_FAR  = 9;
endpackage

// File: rtl/sync_scrambler.sv
module sync_scrambler #(
  parameter int unsigned TAP_NEAR   = 5,
  parameter int unsigned TAP_FAR    = 9,
  parameter bit          DESCRAMBLE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic bit_o
);
  localparam int unsigned LEN = TAP_FAR;

  logic [LEN-1:0] hist_q;
  logic           fb;
  logic           line_bit;

  assign fb    = hist_q[TAP_NEAR-1] ^ hist_q[TAP_FAR-1];
  assign bit_o = bit_i ^ fb;

  // history always tracks the bit that is on the line
  generate
    if (DESCRAMBLE) begin : g_desc
      assign line_bit = bit_i;
    end else begin : g_scr
      assign line_bit = bit_o;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hist_q <= '0;
    else if (en_i) hist_q <= {hist_q[LEN-2:0], line_bit};
  end

  // R5 R9
  hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(hist_q));
endmodule

// File: rtl/ami_encoder.sv
module ami_encoder
  import ami_codec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [1:0] sym_o
);
  logic pol_neg_q;
  logic [1:0] sym_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_neg_q <= 1'b0;
      sym_q     <= SYM_ZERO;
    end else if (en_i && bit_i) begin
      sym_q     <= pol_neg_q ? SYM_NEG : SYM_POS;
      pol_neg_q <= ~pol_neg_q;
    end else begin
      sym_q     <= SYM_ZERO;
    end
  end

  assign sym_o = sym_q;

  // last mark seen on the output, kept for the alternation check only
  logic [1:0] last_mark_q;
  logic       is_mark;
  assign is_mark = (sym_o == SYM_POS) || (sym_o == SYM_NEG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_mark_q <= SYM_ZERO;
    else if (is_mark) last_mark_q <= sym_o;
  end

  // R1
  code_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_o != SYM_BAD);
  // R2
  mark_alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mark && last_mark_q != SYM_ZERO) |-> sym_o != last_mark_q);
  // R2
  first_mark_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mark && last_mark_q == SYM_ZERO) |-> sym_o == SYM_POS);
  // R4
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> sym_o == SYM_ZERO);
endmodule

// File: rtl/ami_decoder.sv
module ami_decoder
  import ami_codec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] sym_i,
  output logic       mark_o,
  output logic       viol_o
);
  logic last_neg_q;
  logic is_neg;

  assign mark_o = (sym_i == SYM_POS) || (sym_i == SYM_NEG);
  assign is_neg = (sym_i == SYM_NEG);
  assign viol_o = en_i && mark_o && (is_neg == last_neg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             last_neg_q <= 1'b1;
    else if (en_i && mark_o) last_neg_q <= is_neg;
  end

  // R9
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(last_neg_q));
endmodule

// File: rtl/ami_line_codec.sv
module ami_line_codec
  import ami_codec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_en_i,
  input  logic       tx_bit_i,
  output logic [1:0] tx_sym_o,
  input  logic       rx_en_i,
  input  logic [1:0] rx_sym_i,
  output logic       rx_bit_o,
  output logic       rx_valid_o,
  output logic       rx_bpv_o
);
  logic tx_scr;
  logic rx_mark, rx_viol, rx_plain;
  logic rx_bit_q, rx_valid_q, rx_bpv_q;

  sync_scrambler #(.TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR), .DESCRAMBLE(1'b0)) u_scr (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(tx_en_i), .bit_i(tx_bit_i), .bit_o(tx_scr)
  );

  ami_encoder u_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tx_en_i), .bit_i(tx_scr), .sym_o(tx_sym_o)
  );

  ami_decoder u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .sym_i(rx_sym_i),
    .mark_o(rx_mark), .viol_o(rx_viol)
  );

  sync_scrambler #(.TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR), .DESCRAMBLE(1'b1)) u_desc (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .bit_i(rx_mark), .bit_o(rx_plain)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_bit_q   <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_bpv_q   <= 1'b0;
    end else begin
      rx_valid_q <= rx_en_i;
      rx_bpv_q   <= rx_viol;
      if (rx_en_i) rx_bit_q <= rx_plain;
    end
  end

  assign rx_bit_o   = rx_bit_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_bpv_o   = rx_bpv_q;

  // R8
  bpv_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_bpv_o |-> rx_valid_o);
  // R9
  rx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (!rx_valid_o && !rx_bpv_o && $stable(rx_bit_o)));
endmodule

// File: tb/ami_line_codec_bench.sv
module ami_line_codec_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, tx_bit = 1'b0, rx_en = 1'b0;
  logic [1:0] rx_sym = 2'b00;
  logic [1:0] tx_sym;
  logic       rx_bit, rx_valid, rx_bpv;

  int n_chk = 0;
  int n_fail = 0;

  // bench model state
  logic [8:0] m_th = '0;
  logic       m_tneg = 1'b0;
  logic [8:0] m_rh = '0;
  logic       m_rneg = 1'b1;
  logic [1:0] e_sym = 2'b00;
  logic       e_bit = 1'b0, e_valid = 1'b0, e_bpv = 1'b0;

  always #10 clk = ~clk;

  ami_line_codec u_ami_line_codec (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_en_i(tx_en), .tx_bit_i(tx_bit), .tx_sym_o(tx_sym),
    .rx_en_i(rx_en), .rx_sym_i(rx_sym),
    .rx_bit_o(rx_bit), .rx_valid_o(rx_valid), .rx_bpv_o(rx_bpv)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] model_tx(input logic en, input logic d);
    logic s;
    if (!en) return 2'b00;
    s = d ^ m_th[4] ^ m_th[8];
    m_th = {m_th[7:0], s};
    if (!s) return 2'b00;
    m_tneg = ~m_tneg;
    return m_tneg ? 2'b01 : 2'b11; // toggled already: was positive if now neg
  endfunction

  task automatic model_rx(input logic en, input logic [1:0] s);
    logic mk, ng;
    e_valid = en;
    e_bpv = 1'b0;
    if (en) begin
      mk = (s == 2'b01) || (s == 2'b11);
      ng = (s == 2'b11);
      e_bpv = mk && (ng == m_rneg);
      if (mk) m_rneg = ng;
      e_bit = mk ^ m_rh[4] ^ m_rh[8];
      m_rh = {m_rh[7:0], mk};
    end
  endtask

  // one symbol period: drive at negedge, model at posedge, check at next negedge
  task automatic step(input logic te, input logic tb, input logic re, input logic [1:0] rs);
    tx_en = te; tx_bit = tb; rx_en = re; rx_sym = rs;
    @(posedge clk);
    e_sym = model_tx(te, tb);
    model_rx(re, rs);
    @(negedge clk);
    if (!te)                 chk("R4 tx idle symbol", tx_sym, e_sym);
    else if (e_sym != 2'b00) chk("R2 tx mark polarity", tx_sym, e_sym);
    else                     chk("R3 tx scrambled zero", tx_sym, e_sym);
    chk("R7 rx valid", rx_valid, e_valid);
    if (re) chk("R7 rx descrambled bit", rx_bit, e_bit);
    else    chk("R9 rx bit held", rx_bit, e_bit);
    chk("R8 rx violation flag", rx_bpv, e_bpv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int streak;
    logic prev_d;
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 tx_sym in reset", tx_sym, 0);
    chk("R11 rx_bit in reset", rx_bit, 0);
    chk("R11 rx_valid in reset", rx_valid, 0);
    chk("R11 rx_bpv in reset", rx_bpv, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 first mark positive; zero history so scrambled bit equals data
    step(1'b1, 1'b1, 1'b1, 2'b11);
    chk("R2 first tx mark positive", tx_sym, 2'b01);
    chk("R8 first rx mark negative is violation", rx_bpv, 1);
    // R6 code 2'b10 is no mark and leaves reference alone
    step(1'b1, 1'b0, 1'b1, 2'b10);
    chk("R6 code 10 gives no violation", rx_bpv, 0);
    step(1'b0, 1'b0, 1'b1, 2'b01);
    chk("R6 reference unchanged by code 10", rx_bpv, 0);
    step(1'b0, 1'b0, 1'b1, 2'b01);
    chk("R8 repeated positive mark flagged", rx_bpv, 1);

    // R5 R9 long gaps between bursts
    for (int i = 0; i < 12; i++) step(1'b0, 1'($urandom), 1'b0, 2'($urandom));
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, 2'b11);
    for (int i = 0; i < 8; i++)  step(1'b0, 1'b1, 1'b0, 2'b01);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b1, 2'b01);

    // random burst windows, all codes, R1 R3 R6 R7 R8
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, 1'($urandom), ($urandom % 3) != 0, 2'($urandom));
      chk("R1 tx code legal", (tx_sym == 2'b10), 0);
    end

    // R10 loopback with injected line errors
    streak = 0;
    prev_d = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      logic d;
      logic [1:0] ls;
      d = 1'($urandom);
      ls = tx_sym;
      if (($urandom % 40) == 0) begin
        ls = (ls == 2'b00) ? 2'b01 : 2'b00;
        streak = 0;
      end else begin
        streak++;
      end
      step(1'b1, d, 1'b1, ls);
      if (streak >= 10) chk("R10 loopback data recovered", rx_bit, prev_d);
      prev_d = d;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule